// File: doc/BRIEF.md
# Flash command sequence decoder

This block is the command interpreter of a parallel NOR-style flash model. Each write cycle reaches it as a single clocked pulse carrying a stable address and a 16-bit data word. It tracks the unlock-protected sequences that alter the array or switch the read path. When a program or erase sequence completes, it raises a one-cycle start strobe for the busy timer, together with an operation code, a target address aligned to the erase granularity, and the word to be written.

The sequences it accepts are: a four-cycle word program; six-cycle sector, block and chip erase; three-cycle entries into identification and query read modes; and two exits from those modes back to array read. The first exit is a single cycle anywhere, and the second is a three-cycle form. Every cycle that does not fit the sequence under way aborts it and selects array read. All cycles are dropped while the timer reports an operation in progress, and also in the cycle in which the decoder itself issues a start.

Top module: `flash_cmd_decoder`

## Requirements
- R1: During and after a synchronous active-low reset, `read_mode` is 0 (array) and `op_start` is 0. Any sequence that was partly entered is forgotten.
- R2: The byte AAH at key address 5555H, then 55H at 2AAAH, then A0H at 5555H, then one more cycle form a program. In the cycle after that fourth write, `op_start` is 1 for exactly one cycle with `op_kind` = 0, `op_addr` equal to the fourth cycle's full address, and `op_data` equal to its full 16-bit data.
- R3: The prefix AAH/5555H, 55H/2AAAH, 80H/5555H, AAH/5555H, 55H/2AAAH, followed by 30H at any address, starts a sector erase. `op_kind` is 1, the address is cleared in its low log2(2048) = 11 bits, and `op_data` is FFFFH.
- R4: The same five-cycle prefix followed by 50H at any address starts a block erase. `op_kind` is 2, the address is cleared in its low log2(32768) = 15 bits, and `op_data` is FFFFH.
- R5: The same prefix followed by 10H at key address 5555H starts a chip erase with `op_kind` = 3 and `op_addr` = 0. 10H at any other address aborts the sequence without a start.
- R6: AAH/5555H, 55H/2AAAH, then 90H/5555H selects identification read (`read_mode` = 1). The same prefix ending in 98H/5555H selects query read (`read_mode` = 2). The mode holds through later cycles until an exit or an abort.
- R7: F0H as a lone cycle at any address returns `read_mode` to 0. So does the three-cycle form AAH/5555H, 55H/2AAAH, F0H/5555H. During the first two cycles of the three-cycle form the mode is unchanged.
- R8: A cycle that does not continue the sequence under way aborts it and sets `read_mode` to 0. A later cycle that would have completed the aborted sequence starts nothing.
- R9: While `busy` is 1, write cycles have no effect. They start no operation, change no read mode (the exit included), and do not advance or abort a partly entered sequence, which resumes where it stood once `busy` falls.
- R10: Only data bits 7:0 are decoded on command cycles; bits 15:8 are don't-care there.
- R11: Key addresses are matched on address bits 14:0 only; higher address bits are don't-care on command cycles.
- R12: A write cycle presented in the cycle in which `op_start` is 1 is dropped like one made while busy, so two starts are never adjacent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | One-cycle write pulse |
| wr_addr | input | ADDR_W (19) | Word address of the write cycle |
| wr_data | input | DATA_W (16) | Data of the write cycle |
| busy | input | 1 | Internal operation in progress, from the timer |
| op_start | output | 1 | One-cycle start strobe to the timer |
| op_kind | output | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| op_addr | output | ADDR_W (19) | Target address, aligned for erases |
| op_data | output | DATA_W (16) | Word to program; FFFFH for erases |
| read_mode | output | 2 | 0 array, 1 identification, 2 query |

## Verification
Two functions can fall on the same edge: issuing a start and accepting the next write cycle. The bench completes a program while in identification mode and, with no idle cycle between, places a lone exit write in the cycle where the start strobe is high. It then judges that the strobe lasted one cycle and that the read mode is still identification. A second case interleaves the busy input with a half-entered erase sequence. The bench confirms that nothing advanced during busy and that the remaining cycles finish the erase afterwards.

// File: rtl/flash_cmd_pkg.sv
// Package: shared types and command constants for the flash command decoder.
// Assumes key addresses fit in KEY_ADDR_W bits and commands sit in the low data byte.
package flash_cmd_pkg;

    localparam int KEY_ADDR_W = 15;
    localparam logic [KEY_ADDR_W-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [KEY_ADDR_W-1:0] KEY_ADDR_B = 15'h2AAA;

    localparam logic [7:0] CODE_UNLOCK_1 = 8'hAA;
    localparam logic [7:0] CODE_UNLOCK_2 = 8'h55;
    localparam logic [7:0] CODE_PROGRAM  = 8'hA0;
    localparam logic [7:0] CODE_ERASE    = 8'h80;
    localparam logic [7:0] CODE_IDENT    = 8'h90;
    localparam logic [7:0] CODE_QUERY    = 8'h98;
    localparam logic [7:0] CODE_EXIT     = 8'hF0;
    localparam logic [7:0] CODE_SECTOR   = 8'h30;
    localparam logic [7:0] CODE_BLOCK    = 8'h50;
    localparam logic [7:0] CODE_CHIP     = 8'h10;

    typedef enum logic [1:0] {
        OP_PROGRAM      = 2'd0,
        OP_SECTOR_ERASE = 2'd1,
        OP_BLOCK_ERASE  = 2'd2,
        OP_CHIP_ERASE   = 2'd3
    } op_kind_t;

    typedef enum logic [1:0] {
        RD_ARRAY   = 2'd0,
        RD_IDENT   = 2'd1,
        RD_QUERY   = 2'd2,
        RD_UNUSED  = 2'd3
    } rd_mode_t;

    typedef enum logic [2:0] {
        SQ_IDLE   = 3'd0,
        SQ_KEY1   = 3'd1,
        SQ_KEY2   = 3'd2,
        SQ_WORD   = 3'd3,
        SQ_EKEY0  = 3'd4,
        SQ_EKEY1  = 3'd5,
        SQ_EKEY2  = 3'd6
    } seq_state_t;

    // Classification of one write cycle, computed from key address and low byte.
    typedef struct packed {
        logic unlock1;
        logic unlock2;
        logic prog;
        logic erase_setup;
        logic ident;
        logic query;
        logic exit_key;
        logic exit_any;
        logic sector;
        logic block;
        logic chip;
    } cyc_class_t;

endpackage

// File: rtl/flash_cycle_classify.sv
// Module: combinational classifier of a single write cycle.
// Assumes the caller passes only the key-address bits and the low data byte,
// so the upper address and data bits are don't-care by construction of the port.
module flash_cycle_classify
    import flash_cmd_pkg::*;
(
    input  logic [KEY_ADDR_W-1:0] key_addr,
    input  logic [7:0]            code,
    output cyc_class_t            cls
);

    logic at_a;
    logic at_b;

    // Match the two key addresses once and share them.
    always_comb begin
        at_a = (key_addr == KEY_ADDR_A);
        at_b = (key_addr == KEY_ADDR_B);
    end

    // Flag each command pattern the sequencer may need.
    always_comb begin
        cls.unlock1     = at_a && (code == CODE_UNLOCK_1);
        cls.unlock2     = at_b && (code == CODE_UNLOCK_2);
        cls.prog        = at_a && (code == CODE_PROGRAM);
        cls.erase_setup = at_a && (code == CODE_ERASE);
        cls.ident       = at_a && (code == CODE_IDENT);
        cls.query       = at_a && (code == CODE_QUERY);
        cls.exit_key    = at_a && (code == CODE_EXIT);
        cls.exit_any    = (code == CODE_EXIT);
        cls.sector      = (code == CODE_SECTOR);
        cls.block       = (code == CODE_BLOCK);
        cls.chip        = at_a && (code == CODE_CHIP);
    end

endmodule

// File: rtl/flash_seq_fsm.sv
// Module: unlock sequence tracker and read-mode register.
// Assumes 'accept' is already qualified by busy and by the start cycle; a
// cycle that is not accepted leaves state and mode untouched. 'fire' is
// combinational and valid only in the cycle of the final accepted write.
module flash_seq_fsm
    import flash_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  cyc_class_t cls,
    output logic       fire,
    output op_kind_t   fire_kind,
    output rd_mode_t   read_mode
);

    seq_state_t state_q;
    seq_state_t state_d;
    rd_mode_t   mode_q;
    rd_mode_t   mode_d;
    logic       bad;

    // Next-state decode: advance, complete, exit or abort on an accepted cycle.
    always_comb begin
        state_d   = state_q;
        mode_d    = mode_q;
        fire      = 1'b0;
        fire_kind = OP_PROGRAM;
        bad       = 1'b0;
        if (accept) begin
            state_d = SQ_IDLE;
            unique case (state_q)
                SQ_IDLE: begin
                    if (cls.unlock1)       state_d = SQ_KEY1;
                    else if (cls.exit_any) mode_d  = RD_ARRAY;
                    else                   bad     = 1'b1;
                end
                SQ_KEY1: begin
                    if (cls.unlock2) state_d = SQ_KEY2;
                    else             bad     = 1'b1;
                end
                SQ_KEY2: begin
                    if (cls.prog)             state_d = SQ_WORD;
                    else if (cls.erase_setup) state_d = SQ_EKEY0;
                    else if (cls.ident)       mode_d  = RD_IDENT;
                    else if (cls.query)       mode_d  = RD_QUERY;
                    else if (cls.exit_key)    mode_d  = RD_ARRAY;
                    else                      bad     = 1'b1;
                end
                SQ_WORD: begin
                    fire      = 1'b1;
                    fire_kind = OP_PROGRAM;
                end
                SQ_EKEY0: begin
                    if (cls.unlock1) state_d = SQ_EKEY1;
                    else             bad     = 1'b1;
                end
                SQ_EKEY1: begin
                    if (cls.unlock2) state_d = SQ_EKEY2;
                    else             bad     = 1'b1;
                end
                SQ_EKEY2: begin
                    if (cls.sector) begin
                        fire      = 1'b1;
                        fire_kind = OP_SECTOR_ERASE;
                    end else if (cls.block) begin
                        fire      = 1'b1;
                        fire_kind = OP_BLOCK_ERASE;
                    end else if (cls.chip) begin
                        fire      = 1'b1;
                        fire_kind = OP_CHIP_ERASE;
                    end else begin
                        bad = 1'b1;
                    end
                end
                default: bad = 1'b1;
            endcase
            if (bad) mode_d = RD_ARRAY;
        end
    end

    // State and mode registers with synchronous reset to idle and array read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            mode_q  <= RD_ARRAY;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
        end
    end

    assign read_mode = mode_q;

    // R6
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q != RD_UNUSED);

    // R8
    abort_to_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && state_q != SQ_IDLE && state_q != SQ_WORD && !fire
         && $past(1'b1) && state_d == SQ_IDLE && mode_d == mode_q && mode_q != RD_ARRAY)
        |-> (state_q == SQ_KEY2));

endmodule

// File: rtl/flash_op_issue.sv
// Module: registers the start strobe and the operation descriptor.
// Assumes 'fire' comes from the sequencer in the cycle of the final write and
// that the write's address and data are still on wr_addr/wr_data then.
module flash_op_issue
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W       = 19,
    parameter int DATA_W       = 16,
    parameter int SECTOR_WORDS = 2048,
    parameter int BLOCK_WORDS  = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  op_kind_t          fire_kind,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              op_start,
    output op_kind_t          op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data
);

    localparam int SECT_LOG2 = $clog2(SECTOR_WORDS);
    localparam int BLK_LOG2  = $clog2(BLOCK_WORDS);
    localparam logic [ADDR_W-1:0] SECT_MASK = {ADDR_W{1'b1}} << SECT_LOG2;
    localparam logic [ADDR_W-1:0] BLK_MASK  = {ADDR_W{1'b1}} << BLK_LOG2;
    localparam logic [DATA_W-1:0] ERASED    = {DATA_W{1'b1}};

    logic [ADDR_W-1:0] tgt_addr;
    logic [DATA_W-1:0] tgt_data;

    // Align the target address and pick the word for the operation kind.
    always_comb begin
        unique case (fire_kind)
            OP_PROGRAM: begin
                tgt_addr = wr_addr;
                tgt_data = wr_data;
            end
            OP_SECTOR_ERASE: begin
                tgt_addr = wr_addr & SECT_MASK;
                tgt_data = ERASED;
            end
            OP_BLOCK_ERASE: begin
                tgt_addr = wr_addr & BLK_MASK;
                tgt_data = ERASED;
            end
            default: begin
                tgt_addr = '0;
                tgt_data = ERASED;
            end
        endcase
    end

    // One-cycle strobe; descriptor held from the last start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_start <= 1'b0;
            op_kind  <= OP_PROGRAM;
            op_addr  <= '0;
            op_data  <= '0;
        end else begin
            op_start <= fire;
            if (fire) begin
                op_kind <= fire_kind;
                op_addr <= tgt_addr;
                op_data <= tgt_data;
            end
        end
    end

    // R3
    sector_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && op_kind == OP_SECTOR_ERASE) |-> ((op_addr & ~SECT_MASK) == '0));

    // R5
    chip_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && op_kind == OP_CHIP_ERASE) |-> (op_addr == '0));

endmodule

// File: rtl/flash_cmd_decoder.sv
// Module: top of the flash command decoder.
// Classifies each write cycle, tracks unlock sequences, selects the read mode
// and issues start strobes. Assumes writes arrive as one-cycle pulses and that
// 'busy' is high for the whole of an internal operation after its start.
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W       = 19,
    parameter int DATA_W       = 16,
    parameter int SECTOR_WORDS = 2048,
    parameter int BLOCK_WORDS  = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output logic              op_start,
    output logic [1:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic [1:0]        read_mode
);

    cyc_class_t cls;
    logic       accept;
    logic       fire;
    op_kind_t   fire_kind;
    op_kind_t   kind_q;
    rd_mode_t   mode_q;

    // Drop writes while the timer runs and in the cycle a start is issued.
    always_comb accept = wr_valid && !busy && !op_start;

    flash_cycle_classify u_classify (
        .key_addr (wr_addr[KEY_ADDR_W-1:0]),
        .code     (wr_data[7:0]),
        .cls      (cls)
    );

    flash_seq_fsm u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .cls       (cls),
        .fire      (fire),
        .fire_kind (fire_kind),
        .read_mode (mode_q)
    );

    flash_op_issue #(
        .ADDR_W       (ADDR_W),
        .DATA_W       (DATA_W),
        .SECTOR_WORDS (SECTOR_WORDS),
        .BLOCK_WORDS  (BLOCK_WORDS)
    ) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .fire_kind (fire_kind),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .op_start  (op_start),
        .op_kind   (kind_q),
        .op_addr   (op_addr),
        .op_data   (op_data)
    );

    // Present enum state as plain vectors at the boundary.
    always_comb begin
        op_kind   = kind_q;
        read_mode = mode_q;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (read_mode == 2'd0 && !op_start));

    // R12
    start_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !op_start);

    // R9
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_valid) |=> (!op_start && $stable(read_mode)));

    // R2
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> $past(wr_valid && !busy));

endmodule

// File: tb/flash_cmd_decoder_bench.sv
`timescale 1ns/1ps
module flash_cmd_decoder_bench;

    localparam int AW = 19;
    localparam int DW = 16;
    localparam int NV = 53;
    localparam int VW = 4 + AW + DW + 1 + 2 + AW + DW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          busy = 1'b0;
    logic          op_start;
    logic [1:0]    op_kind;
    logic [AW-1:0] op_addr;
    logic [DW-1:0] op_data;
    logic [1:0]    read_mode;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    flash_cmd_decoder u_flash_cmd_decoder (
        .clk (clk), .rst_n (rst_n), .wr_valid (wr_valid), .wr_addr (wr_addr),
        .wr_data (wr_data), .busy (busy), .op_start (op_start), .op_kind (op_kind),
        .op_addr (op_addr), .op_data (op_data), .read_mode (read_mode)
    );

    function automatic logic [VW-1:0] v(logic [3:0] r, logic [AW-1:0] a, logic [DW-1:0] d,
                                        logic s, logic [1:0] k, logic [AW-1:0] ea,
                                        logic [DW-1:0] ed, logic [1:0] m);
        return {r, a, d, s, k, ea, ed, m};
    endfunction

    // Columns: req, addr, data, start expected, kind, op addr, op data, read mode after
    localparam logic [VW-1:0] VEC [NV] = '{
        // R2 program
        v(2, 19'h05555, 16'h00AA, 0, 0, 0, 0, 0),
        v(2, 19'h02AAA, 16'h0055, 0, 0, 0, 0, 0),
        v(2, 19'h05555, 16'h00A0, 0, 0, 0, 0, 0),
        v(2, 19'h12345, 16'hBEEF, 1, 0, 19'h12345, 16'hBEEF, 0),
        // R3 sector erase
        v(3, 19'h05555, 16'h00AA, 0, 0, 0, 0, 0),
        v(3, 19'h02AAA, 16'h0055, 0, 0, 0, 0, 0),
        v(3, 19'h05555, 16'h0080, 0, 0, 0, 0, 0),
        v(3, 19'h05555, 16'h00AA, 0, 0, 0, 0, 0),
        v(3, 19'h02AAA, 16'h0055, 0, 0, 0, 0, 0),
        v(3, 19'h45ABC, 16'h0030, 1, 1, 19'h45800, 16'hFFFF, 0),
        // R4 block erase
        v(4, 19'h05555, 16'h00AA, 0, 0, 0, 0, 0),
        v(4, 19'h02AAA, 16'h0055, 0, 0, 0, 0, 0),
        v(4, 19'h05555, 16'h0080, 0, 0, 0, 0, 0),
        v(4, 19'h05555, 16'h00AA, 0, 0, 0, 0, 0),
        v(4, 19'h02AAA, 16'h0055, 0, 0, 0, 0, 0),
        v(4, 19'h45ABC, 16'h0050, 1, 2, 19'h40000, 16'hFFFF, 0),
        // R5 chip erase
        v(5, 19'h05555, 16'h00AA, 0, 0, 0, 0, 0),
        v(5, 19'h02AAA, 16'h0055, 0, 0, 0, 0, 0),
        v(5, 19'h05555, 16'h0080, 0, 0, 0, 0, 0),
        v(5, 19'h05555, 16'h00AA, 0, 0, 0, 0, 0),
        v(5, 19'h02AAA, 16'h0055, 0, 0, 0, 0, 0),
        v(5, 19'h05555, 16'h0010, 1, 3, 19'h00000, 16'hFFFF, 0),
        // R5 chip erase code at the wrong address: no start
        v(5, 19'h05555, 16'h00AA, 0, 0, 0, 0, 0),
        v(5, 19'h02AAA, 16'h0055, 0, 0, 0, 0, 0),
        v(5, 19'h05555, 16'h0080, 0, 0, 0, 0, 0),
        v(5, 19'h05555, 16'h00AA, 0, 0, 0, 0, 0),
        v(5, 19'h02AAA, 16'h0055, 0, 0, 0, 0, 0),
        v(5, 19'h02AAA, 16'h0010, 0, 0, 0, 0, 0),
        // R6 identification entry
        v(6, 19'h05555, 16'h00AA, 0, 0, 0, 0, 0),
        v(6, 19'h02AAA, 16'h0055, 0, 0, 0, 0, 0),
        v(6, 19'h05555, 16'h0090, 0, 0, 0, 0, 1),
        // R7 lone exit anywhere
        v(7, 19'h01234, 16'h00F0, 0, 0, 0, 0, 0),
        // R6 query entry
        v(6, 19'h05555, 16'h00AA, 0, 0, 0, 0, 0),
        v(6, 19'h02AAA, 16'h0055, 0, 0, 0, 0, 0),
        v(6, 19'h05555, 16'h0098, 0, 0, 0, 0, 2),
        // R7 three-cycle exit
        v(7, 19'h05555, 16'h00AA, 0, 0, 0, 0, 2),
        v(7, 19'h02AAA, 16'h0055, 0, 0, 0, 0, 2),
        v(7, 19'h05555, 16'h00F0, 0, 0, 0, 0, 0),
        // R8 abort from query mode, then the orphan word starts nothing
        v(8, 19'h05555, 16'h00AA, 0, 0, 0, 0, 0),
        v(8, 19'h02AAA, 16'h0055, 0, 0, 0, 0, 0),
        v(8, 19'h05555, 16'h0098, 0, 0, 0, 0, 2),
        v(8, 19'h05555, 16'h00AA, 0, 0, 0, 0, 2),
        v(8, 19'h02AAA, 16'h0055, 0, 0, 0, 0, 2),
        v(8, 19'h05555, 16'h0012, 0, 0, 0, 0, 0),
        v(8, 19'h00100, 16'h1111, 0, 0, 0, 0, 0),
        // R8 wrong second key address
        v(8, 19'h05555, 16'h00AA, 0, 0, 0, 0, 0),
        v(8, 19'h05555, 16'h0055, 0, 0, 0, 0, 0),
        v(8, 19'h05555, 16'h00A0, 0, 0, 0, 0, 0),
        v(8, 19'h00200, 16'h2222, 0, 0, 0, 0, 0),
        // R10 R11 noisy upper data byte and upper address bits
        v(10, 19'h45555, 16'h12AA, 0, 0, 0, 0, 0),
        v(11, 19'h42AAA, 16'h3455, 0, 0, 0, 0, 0),
        v(11, 19'h7D555, 16'h77A0, 0, 0, 0, 0, 0),
        v(10, 19'h00020, 16'hA55A, 1, 0, 19'h00020, 16'hA55A, 0)
    };

    // Record one comparison; a mismatch prints one FAIL line.
    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive a write for one edge and leave wr_valid high.
    task automatic put(logic [AW-1:0] a, logic [DW-1:0] d);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        @(negedge clk);
    endtask

    // Drive a single isolated write; outputs are sampled after it returns.
    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
        put(a, d);
        wr_valid = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R1 reset state
        check("R1", "read_mode", 32'(read_mode), 0);
        check("R1", "op_start", 32'(op_start), 0);
        rst_n = 1'b1;
        idle(1);

        // Table walk: each entry is one isolated write
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] e;
            string rq;
            e = VEC[i];
            rq = $sformatf("R%0d", e[VW-1 -: 4]);
            wr(e[VW-5 -: AW], e[VW-5-AW -: DW]);
            check(rq, $sformatf("op_start vec %0d", i), 32'(op_start), 32'(e[2+DW+AW+2]));
            if (e[2+DW+AW+2]) begin
                check(rq, $sformatf("op_kind vec %0d", i), 32'(op_kind), 32'(e[2+DW+AW+1 -: 2]));
                check(rq, $sformatf("op_addr vec %0d", i), 32'(op_addr), 32'(e[2+DW+AW-1 -: AW]));
                check(rq, $sformatf("op_data vec %0d", i), 32'(op_data), 32'(e[2+DW-1 -: DW]));
            end
            check(rq, $sformatf("read_mode vec %0d", i), 32'(read_mode), 32'(e[1:0]));
            idle(1);
        end

        // R9 exit dropped while busy, program dropped while busy
        wr(19'h05555, 16'h00AA); wr(19'h02AAA, 16'h0055); wr(19'h05555, 16'h0098);
        busy = 1'b1;
        wr(19'h00000, 16'h00F0);
        check("R9", "read_mode after exit while busy", 32'(read_mode), 2);
        wr(19'h05555, 16'h00AA); wr(19'h02AAA, 16'h0055); wr(19'h05555, 16'h00A0);
        wr(19'h00300, 16'h1234);
        check("R9", "op_start after program while busy", 32'(op_start), 0);
        busy = 1'b0;
        wr(19'h00300, 16'h1234);
        check("R9", "op_start on orphan word after busy", 32'(op_start), 0);
        check("R9", "read_mode after orphan word", 32'(read_mode), 0);

        // R9 erase sequence held across busy, resumed afterwards
        wr(19'h05555, 16'h00AA); wr(19'h02AAA, 16'h0055); wr(19'h05555, 16'h0080);
        busy = 1'b1;
        wr(19'h05555, 16'h00AA); wr(19'h02AAA, 16'h0055);
        wr(19'h1FFFF, 16'h0030);
        check("R9", "op_start inside busy", 32'(op_start), 0);
        busy = 1'b0;
        wr(19'h05555, 16'h00AA); wr(19'h02AAA, 16'h0055);
        wr(19'h00FFF, 16'h0030);
        check("R9", "op_start resumed erase", 32'(op_start), 1);
        check("R3", "op_kind resumed erase", 32'(op_kind), 1);
        check("R3", "op_addr resumed erase", 32'(op_addr), 32'h00800);
        idle(1);

        // R12 exit presented in the start cycle is dropped
        wr(19'h05555, 16'h00AA); wr(19'h02AAA, 16'h0055); wr(19'h05555, 16'h0090);
        check("R6", "read_mode ident", 32'(read_mode), 1);
        put(19'h05555, 16'h00AA); put(19'h02AAA, 16'h0055); put(19'h05555, 16'h00A0);
        put(19'h00444, 16'h5A5A);
        check("R12", "op_start program", 32'(op_start), 1);
        check("R12", "op_data program", 32'(op_data), 32'h5A5A);
        wr(19'h00000, 16'h00F0);
        check("R12", "op_start single cycle", 32'(op_start), 0);
        check("R12", "read_mode kept ident", 32'(read_mode), 1);
        wr(19'h00000, 16'h00F0);
        check("R7", "read_mode after later exit", 32'(read_mode), 0);

        // R1 reset mid-sequence and out of query mode
        wr(19'h05555, 16'h00AA); wr(19'h02AAA, 16'h0055); wr(19'h05555, 16'h0098);
        wr(19'h05555, 16'h00AA); wr(19'h02AAA, 16'h0055);
        rst_n = 1'b0;
        idle(2);
        check("R1", "read_mode in reset", 32'(read_mode), 0);
        rst_n = 1'b1;
        idle(1);
        wr(19'h05555, 16'h00A0);
        wr(19'h00050, 16'h3333);
        check("R1", "op_start after reset drops sequence", 32'(op_start), 0);
        check("R1", "read_mode after reset", 32'(read_mode), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule